// File: doc/BRIEF.md
# Tagged Receive Character Queue

This block sits between a serial receive engine and the host side of a serial port. Each character the engine finishes arrives with a write strobe, eight data bits and three error tags. The block stores these together as one entry, so a tag always stays with its own byte. The host sees the oldest unread entry on a holding-register style output and removes it with a read strobe. The tags shown on the output change in the same cycle as the data when the head advances.

An enable input selects between queue mode, with 64 entries, and single holding-register mode, with one entry. One interrupt line reports two causes. The first is received data: in queue mode this fires when the fill reaches a level chosen by a 2-bit code, and in single mode it fires as soon as a character is held. The second is a character timeout, raised when stored data has waited a set number of bit ticks with no arrival or read. The timeout makes sure a partly filled queue still reaches the host.

Top module: `rx_tag_fifo`

## Requirements
- R1: Each stored entry keeps its 8-bit data and 3-bit tags together. The head outputs show the oldest unread entry in arrival order. `data_rdy` is high exactly when at least one entry is stored. While the block is empty, the head outputs are zero.
- R2: A `rd_en` pulse while the block is non-empty removes the head. In the next cycle, `head_data` and `head_tags` both show the following entry.
- R3: A `rd_en` pulse while the block is empty has no effect. A later write becomes the head.
- R4: With `fifo_on` high, up to 64 entries are held.
- R5: A write that arrives while the block is full is dropped. It leaves the stored contents and the head unchanged, and it sets the sticky `ovr_flag`. A pulse on `ovr_clr` clears `ovr_flag`.
- R6: With `fifo_on` high, the data cause of the interrupt is active while the fill is at least the trigger level. `trig_sel` picks the level: 0 gives 8, 1 gives 16, 2 gives 56, 3 gives 60.
- R7: With `fifo_on` low, only one entry is held, and the data cause of the interrupt is active while that entry is present.
- R8: The timeout cause becomes active once the block is non-empty and `bit_tick` has been high in 4×(L+2)+12 clock cycles with no accepted write and no read in between. L is 5 + `wlen_sel`, so the counts are 40, 44, 48 and 52. Any accepted write or read restarts the count, and emptying the block clears the timeout cause.
- R9: `irq` equals `irq_en` ANDed with the OR of the data cause and the timeout cause.
- R10: Any change of `fifo_on` discards all stored entries and leaves `ovr_flag` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Character write strobe from the receive engine |
| wr_data | input | 8 | Received character |
| wr_tags | input | 3 | Error tags of the received character |
| rd_en | input | 1 | Host read strobe of the holding register |
| fifo_on | input | 1 | 1: 64-entry queue mode, 0: single holding register |
| irq_en | input | 1 | Receive interrupt enable |
| trig_sel | input | 2 | Trigger level code |
| wlen_sel | input | 2 | Word length code (5 to 8 bits) |
| bit_tick | input | 1 | One pulse per bit time |
| ovr_clr | input | 1 | Clears the overrun flag |
| head_data | output | 8 | Data of the oldest unread entry |
| head_tags | output | 3 | Tags of the oldest unread entry |
| data_rdy | output | 1 | At least one entry stored |
| irq | output | 1 | Receive interrupt |
| ovr_flag | output | 1 | Sticky overrun flag |

## Verification
The bench builds the block with its default depth of 64. At that depth the 56 and 60 trigger levels sit close to the top, so one directed run can fill the queue across the 59/60 boundary, reach the full condition, and push a 65th write that must be dropped. The 6-bit timeout counter reaches its 40 and 52 tick limits in a few hundred cycles. This brings the exact cycle of expiry, and its restart by a write or a read, within reach of short tasks.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
  localparam int DATA_W = 8;
  localparam int TAG_W  = 3;

  typedef struct packed {
    logic [TAG_W-1:0]  tags;
    logic [DATA_W-1:0] data;
  } rxq_entry_t;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_on,
  input  logic          wr_en,
  input  rxq_entry_t    wr_entry,
  input  logic          rd_en,
  input  logic          ovr_clr,
  output rxq_entry_t    head,
  output logic [CW-1:0] fill,
  output logic          full,
  output logic          push,
  output logic          pop,
  output logic          flush,
  output logic          ovr
);
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);
  localparam logic [CW-1:0] ONE_LVL  = CW'(1);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  rxq_entry_t    mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] fill_q, fill_d;
  logic          mode_q;
  logic          ovr_q, ovr_d;
  logic          empty;

  assign empty = (fill_q == '0);
  assign full  = (fill_q == (fifo_on ? FULL_LVL : ONE_LVL));
  assign flush = (fifo_on != mode_q);
  assign push  = wr_en && !full && !flush;
  assign pop   = rd_en && !empty && !flush;

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    fill_d   = fill_q;
    ovr_d    = ovr_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      fill_d   = '0;
    end else begin
      if (push) wr_ptr_d = (wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + AW'(1);
      if (pop)  rd_ptr_d = (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + AW'(1);
      case ({push, pop})
        2'b10:   fill_d = fill_q + ONE_LVL;
        2'b01:   fill_d = fill_q - ONE_LVL;
        default: fill_d = fill_q;
      endcase
    end
    if (ovr_clr) ovr_d = 1'b0;
    if (wr_en && full && !flush) ovr_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      fill_q   <= '0;
      mode_q   <= 1'b0;
      ovr_q    <= 1'b0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      fill_q   <= fill_d;
      mode_q   <= fifo_on;
      ovr_q    <= ovr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr_q] <= wr_entry;
  end

  assign head = empty ? '0 : mem[rd_ptr_q];
  assign fill = fill_q;
  assign ovr  = ovr_q;
endmodule

// File: rtl/rxq_timeout.sv
module rxq_timeout #(
  parameter int MIN_WORD   = 5,
  parameter int CHAR_MULT  = 4,
  parameter int GUARD_BITS = 12,
  localparam int BASE_LIM  = CHAR_MULT * (MIN_WORD + 2) + GUARD_BITS,
  localparam int MAX_LIM   = BASE_LIM + CHAR_MULT * 3,
  localparam int CNT_W     = $clog2(MAX_LIM + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_tick,
  input  logic       active,
  input  logic       restart,
  input  logic [1:0] wlen_sel,
  output logic       expired
);
  logic [CNT_W-1:0] cnt_q, cnt_d, limit;

  assign limit = CNT_W'(BASE_LIM + CHAR_MULT * int'(wlen_sel));

  always_comb begin
    cnt_d = cnt_q;
    if (restart || !active)            cnt_d = '0;
    else if (bit_tick && cnt_q < limit) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = active && (cnt_q >= limit);
endmodule

// File: rtl/rxq_irq_gen.sv
module rxq_irq_gen #(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          fifo_on,
  input  logic [1:0]    trig_sel,
  input  logic [CW-1:0] fill,
  input  logic          expired,
  input  logic          irq_en,
  output logic          irq
);
  logic [CW-1:0] trig_lvl;
  logic          lvl_hit;

  always_comb begin
    case (trig_sel)
      2'd0:    trig_lvl = CW'(DEPTH / 8);
      2'd1:    trig_lvl = CW'(DEPTH / 4);
      2'd2:    trig_lvl = CW'(DEPTH - 8);
      default: trig_lvl = CW'(DEPTH - 4);
    endcase
  end

  assign lvl_hit = fifo_on ? (fill >= trig_lvl) : (fill != '0);
  assign irq     = irq_en && (lvl_hit || expired);
endmodule

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [TAG_W-1:0]  wr_tags,
  input  logic              rd_en,
  input  logic              fifo_on,
  input  logic              irq_en,
  input  logic [1:0]        trig_sel,
  input  logic [1:0]        wlen_sel,
  input  logic              bit_tick,
  input  logic              ovr_clr,
  output logic [DATA_W-1:0] head_data,
  output logic [TAG_W-1:0]  head_tags,
  output logic              data_rdy,
  output logic              irq,
  output logic              ovr_flag
);
  logic [1:0]    rst_sync_q;
  logic          rst_int_n;
  rxq_entry_t    wr_entry, head;
  logic [CW-1:0] fill;
  logic          full, push, pop, flush, expired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign wr_entry.data = wr_data;
  assign wr_entry.tags = wr_tags;

  rxq_store #(.DEPTH(DEPTH)) store_i (
    .clk(clk), .rst_n(rst_int_n), .fifo_on(fifo_on), .wr_en(wr_en),
    .wr_entry(wr_entry), .rd_en(rd_en), .ovr_clr(ovr_clr), .head(head),
    .fill(fill), .full(full), .push(push), .pop(pop), .flush(flush),
    .ovr(ovr_flag)
  );

  rxq_timeout tmo_i (
    .clk(clk), .rst_n(rst_int_n), .bit_tick(bit_tick),
    .active(fill != '0), .restart(push || pop), .wlen_sel(wlen_sel),
    .expired(expired)
  );

  rxq_irq_gen #(.DEPTH(DEPTH)) irq_i (
    .fifo_on(fifo_on), .trig_sel(trig_sel), .fill(fill),
    .expired(expired), .irq_en(irq_en), .irq(irq)
  );

  assign head_data = head.data;
  assign head_tags = head.tags;
  assign data_rdy  = (fill != '0);
endmodule

// File: rtl/rx_tag_fifo_checker.sv
module rx_tag_fifo_checker #(
  parameter int DEPTH = 64,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          fifo_on,
  input logic          bit_tick,
  input logic [1:0]    wlen_sel,
  input logic          data_rdy,
  input logic          ovr_flag,
  input logic [CW-1:0] fill,
  input logic          full,
  input logic          push,
  input logic          pop,
  input logic          flush,
  input logic          expired
);
  localparam logic [CW-1:0] ONE_LVL = CW'(1);
  localparam logic [CW-1:0] TOP_LVL = CW'(DEPTH);

  assert_push_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> data_rdy);

  assert_pop_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> (fill == $past(fill) - ONE_LVL));

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= TOP_LVL);

  assert_drop_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !flush && !pop) |=> (fill == $past(fill)));

  assert_overrun_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && full && !flush) |=> ovr_flag);

  assert_single_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_on && !flush) |-> (fill <= ONE_LVL));

  assert_timeout_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(expired) && $stable(wlen_sel)) |-> $past(bit_tick));

  assert_flush_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !data_rdy);
endmodule

bind rx_tag_fifo rx_tag_fifo_checker #(.DEPTH(DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_int_n), .wr_en(wr_en), .fifo_on(fifo_on),
  .bit_tick(bit_tick), .wlen_sel(wlen_sel), .data_rdy(data_rdy),
  .ovr_flag(ovr_flag), .fill(fill), .full(full), .push(push), .pop(pop),
  .flush(flush), .expired(expired)
);

// File: tb/rx_tag_fifo_tb_top.sv
`timescale 1ns/1ps
module rx_tag_fifo_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, rd_en, fifo_on, irq_en, bit_tick, ovr_clr;
  logic [7:0] wr_data;
  logic [2:0] wr_tags;
  logic [1:0] trig_sel, wlen_sel;
  logic [7:0] head_data;
  logic [2:0] head_tags;
  logic       data_rdy, irq, ovr_flag;

  int n_run  = 0;
  int n_fail = 0;
  logic [10:0] mq[$];
  int cap;

  always #2.5 clk = ~clk;

  rx_tag_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .wr_tags(wr_tags), .rd_en(rd_en), .fifo_on(fifo_on), .irq_en(irq_en),
    .trig_sel(trig_sel), .wlen_sel(wlen_sel), .bit_tick(bit_tick),
    .ovr_clr(ovr_clr), .head_data(head_data), .head_tags(head_tags),
    .data_rdy(data_rdy), .irq(irq), .ovr_flag(ovr_flag)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic fo, input logic ie, input logic [1:0] ts, input logic [1:0] ws);
    @(negedge clk);
    rst_n = 1'b0; wr_en = 0; rd_en = 0; bit_tick = 0; ovr_clr = 0;
    wr_data = 0; wr_tags = 0;
    fifo_on = fo; irq_en = ie; trig_sel = ts; wlen_sel = ws;
    cap = fo ? 64 : 1;
    mq.delete();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic put(input logic [7:0] d, input logic [2:0] t);
    wr_en = 1; wr_data = d; wr_tags = t;
    @(negedge clk);
    wr_en = 0;
    if (mq.size() < cap) mq.push_back({t, d});
  endtask

  task automatic take();
    rd_en = 1;
    @(negedge clk);
    rd_en = 0;
    if (mq.size() > 0) void'(mq.pop_front());
  endtask

  task automatic ticks(input int n);
    bit_tick = 1;
    repeat (n) @(negedge clk);
    bit_tick = 0;
  endtask

  task automatic check_head(input string req);
    int ed, et;
    ed = mq.size() > 0 ? int'(mq[0][7:0]) : 0;
    et = mq.size() > 0 ? int'(mq[0][10:8]) : 0;
    check(req, "head_data", int'(head_data), ed);
    check(req, "head_tags", int'(head_tags), et);
    check(req, "data_rdy", int'(data_rdy), int'(mq.size() > 0));
  endtask

  task automatic t_reset();
    do_reset(1, 1, 0, 0);
    check("R1", "reset data_rdy", int'(data_rdy), 0);
    check("R1", "reset head_data", int'(head_data), 0);
    check("R9", "reset irq", int'(irq), 0);
    check("R5", "reset ovr_flag", int'(ovr_flag), 0);
  endtask

  task automatic t_order_tags();
    do_reset(1, 0, 0, 0);
    put(8'hA1, 3'd1); check_head("R1");
    put(8'h52, 3'd6);
    put(8'h03, 3'd0);
    put(8'hFF, 3'd7);
    check_head("R1");
    for (int i = 0; i < 4; i++) begin
      take();
      check_head("R2");
    end
  endtask

  task automatic t_read_empty();
    do_reset(1, 0, 0, 0);
    take();
    check("R3", "data_rdy after empty read", int'(data_rdy), 0);
    put(8'h3C, 3'd5);
    put(8'h4D, 3'd2);
    check_head("R3");
    take();
    check_head("R3");
  endtask

  task automatic t_trig_low();
    do_reset(1, 1, 0, 3);
    for (int i = 0; i < 7; i++) put(8'(i), 3'd0);
    check("R6", "irq at fill 7 level 8", int'(irq), 0);
    put(8'h07, 3'd0);
    check("R6", "irq at fill 8 level 8", int'(irq), 1);
    take();
    check("R6", "irq after drop to 7", int'(irq), 0);
    do_reset(1, 1, 1, 3);
    for (int i = 0; i < 15; i++) put(8'(i), 3'd0);
    check("R6", "irq at fill 15 level 16", int'(irq), 0);
    put(8'h0F, 3'd0);
    check("R6", "irq at fill 16 level 16", int'(irq), 1);
  endtask

  task automatic t_full();
    do_reset(1, 1, 3, 3);
    for (int i = 0; i < 59; i++) put(8'(i + 16), 3'(i));
    check("R6", "irq at fill 59 level 60", int'(irq), 0);
    put(8'(59 + 16), 3'(59));
    check("R6", "irq at fill 60 level 60", int'(irq), 1);
    for (int i = 60; i < 64; i++) put(8'(i + 16), 3'(i));
    check("R4", "ovr after 64 writes", int'(ovr_flag), 0);
    put(8'hEE, 3'd7);
    check("R5", "ovr after drop", int'(ovr_flag), 1);
    check_head("R5");
    for (int i = 0; i < 64; i++) begin
      check("R4", "head of full drain", int'(head_data), i + 16);
      take();
    end
    check("R5", "empty after 64 reads", int'(data_rdy), 0);
    check("R5", "ovr sticky", int'(ovr_flag), 1);
    ovr_clr = 1; @(negedge clk); ovr_clr = 0;
    check("R5", "ovr cleared", int'(ovr_flag), 0);
  endtask

  task automatic t_single();
    do_reset(0, 1, 3, 0);
    check("R7", "irq empty single", int'(irq), 0);
    put(8'h11, 3'd3);
    check("R7", "irq holding single", int'(irq), 1);
    put(8'h22, 3'd4);
    check("R7", "ovr second write", int'(ovr_flag), 1);
    check_head("R7");
    take();
    check("R7", "data_rdy after read", int'(data_rdy), 0);
    put(8'h22, 3'd4);
    check_head("R7");
  endtask

  task automatic t_gate();
    do_reset(1, 0, 0, 0);
    for (int i = 0; i < 8; i++) put(8'(i), 3'd0);
    check("R9", "irq gated off", int'(irq), 0);
    irq_en = 1;
    @(negedge clk);
    check("R9", "irq gated on", int'(irq), 1);
  endtask

  task automatic t_timeout();
    do_reset(1, 1, 3, 0);
    ticks(60);
    put(8'h5A, 3'd0);
    ticks(39);
    check("R8", "irq after 39 ticks len5", int'(irq), 0);
    ticks(1);
    check("R8", "irq after 40 ticks len5", int'(irq), 1);
    take();
    check("R8", "irq after emptying", int'(irq), 0);
    put(8'h01, 3'd0);
    put(8'h02, 3'd0);
    ticks(35);
    take();
    ticks(39);
    check("R8", "irq read restart 39", int'(irq), 0);
    ticks(1);
    check("R8", "irq read restart 40", int'(irq), 1);
    do_reset(1, 1, 3, 3);
    put(8'h77, 3'd1);
    ticks(30);
    put(8'h78, 3'd1);
    ticks(51);
    check("R8", "irq write restart 51 len8", int'(irq), 0);
    ticks(1);
    check("R8", "irq write restart 52 len8", int'(irq), 1);
  endtask

  task automatic t_flush();
    do_reset(1, 0, 0, 0);
    put(8'h10, 3'd1);
    put(8'h20, 3'd2);
    fifo_on = 0; cap = 1; mq.delete();
    @(negedge clk);
    check("R10", "data_rdy after mode change", int'(data_rdy), 0);
    check("R10", "ovr after mode change", int'(ovr_flag), 0);
    put(8'h30, 3'd3);
    check_head("R10");
  endtask

  initial begin
    rst_n = 1'b0;
    t_reset();
    t_order_tags();
    t_read_empty();
    t_trig_low();
    t_full();
    t_single();
    t_gate();
    t_timeout();
    t_flush();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule